// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block collects up to twenty-nine level-type interrupt sources into a cause register. It gates them with a mask register and raises one interrupt line toward the processor. Each source owns one cause bit, at positions 1 to 29. The interrupt number is a fixed base plus that bit index. A rising source sets its bit, and the bit stays set until software clears it. Three more positions of the cause view are not storage. Bit 0, bit 30 and bit 31 are OR summaries over fixed groups of source bits, so software can tell at a glance which group needs service.

Software reaches both registers through a small register port. Reads are combinational and writes complete on the clock edge. To clear a source, software writes the cause word back with that one bit at 0. Bits written as 1 are left as they were, so a read-modify-write never sets anything. A priority encoder reports the lowest-numbered source that is both pending and enabled, and a valid flag covers the case where nothing is pending.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset both registers hold zero, so address 0 and address 1 read 0, `cpuIrq` is low and `vecValid` is low.
- R2: If `srcIn[i]` is high at a clock edge, cause bit i (1..29) is set after that edge. The bit stays set after the source drops.
- R3: A write to address 0 clears every stored source bit written as 0. Source bits written as 1 are left unchanged.
- R4: If a source is high on the same edge as a write that clears its bit, the bit stays set.
- R5: Cause-word bits 0, 30 and 31 are computed and never stored. Writes to those positions have no effect on them.
- R6: In the cause view read at address 0, bit 0 is the OR of source bits 29..1. Bit 30 is the OR of bits 29..26 and 20..1. Bit 31 is the OR of bits 25..1.
- R7: Address 1 is the mask register, and a mask bit of 1 enables its source. Mask bits 0, 30 and 31 always read 0.
- R8: `cpuIrq` is high exactly when at least one source bit has both its cause bit and its mask bit at 1.
- R9: `vecIndex` is the lowest-numbered pending, enabled source, and `vecValid` is high when such a source exists. When none exists, `vecValid` is low and `vecIndex` reads 0.
- R10: Masking a source does not change its cause bit. Re-enabling the source raises the interrupt again.
- R11: Addresses 2 and 3 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 29 | Source levels, index i feeds cause bit i (range 29:1) |
| regAddr | input | 2 | Register word address: 0 cause, 1 mask |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data of the addressed register |
| cpuIrq | output | 1 | Level interrupt request to the processor |
| vecValid | output | 1 | A pending, enabled source exists |
| vecIndex | output | 5 | Bit index of the winning source |

## Verification
The hardest case to reach is a source held high on the very edge at which software writes its cause bit to 0. Only there does set take priority over clear. The stimulus raises the source one cycle before the clearing write and keeps it high through the write edge. It then drops the source and reads the bit back. The same clear is then repeated with the source low, to show that the bit does clear. The summary positions are reached by latching single sources chosen at the edges of each irregular group (1, 20, 21, 25, 26 and 29), one at a time.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  parameter int DATA_W = 32;
  parameter int ADDR_W = 2;
  parameter int SRC_LO = 1;
  parameter int SRC_HI = 29;
  parameter int IDX_W  = $clog2(SRC_HI + 1);

  // summary positions in the cause view
  parameter int SUM_ALL_POS = 0;
  parameter int SUM_A_POS   = 30;
  parameter int SUM_B_POS   = 31;

  parameter logic [ADDR_W-1:0] ADDR_CAUSE = ADDR_W'(0);
  parameter logic [ADDR_W-1:0] ADDR_MASK  = ADDR_W'(1);

  function automatic logic [DATA_W-1:0] bitRange(int hi, int lo);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i >= lo && i <= hi) r[i] = 1'b1;
    end
    return r;
  endfunction

  parameter logic [DATA_W-1:0] SRC_FIELD = bitRange(SRC_HI, SRC_LO);
  // group feeding summary position 30: upper four sources plus the low twenty
  parameter logic [DATA_W-1:0] GRP_A = bitRange(29, 26) | bitRange(20, 1);
  // group feeding summary position 31: sources 25 down to 1
  parameter logic [DATA_W-1:0] GRP_B = bitRange(25, 1);

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_CAUSE = 2'd1,
    RD_MASK  = 2'd2
  } rd_sel_e;

  typedef struct packed {
    logic    causeWr;
    logic    maskWr;
    rd_sel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/irq_ctrl_prienc.sv
module irq_ctrl_prienc
  import irq_ctrl_pkg::*;
#(
  parameter int LO = SRC_LO,
  parameter int HI = SRC_HI,
  parameter int IW = IDX_W
) (
  input  logic [HI:LO]  pend,
  output logic          valid,
  output logic [IW-1:0] idx
);

  // scan from the top down so the lowest set index is the last one written
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = HI; i >= LO; i--) begin
      if (pend[i]) begin
        valid = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_ctrl_ctrl.sv
module irq_ctrl_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobe_t           strobe
);

  always_comb begin
    strobe.causeWr = 1'b0;
    strobe.maskWr  = 1'b0;
    strobe.rdSel   = RD_NONE;
    case (regAddr)
      ADDR_CAUSE: begin
        strobe.causeWr = regWrEn;
        strobe.rdSel   = RD_CAUSE;
      end
      ADDR_MASK: begin
        strobe.maskWr = regWrEn;
        strobe.rdSel  = RD_MASK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_ctrl_data.sv
module irq_ctrl_data
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_HI:SRC_LO] srcIn,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              cpuIrq,
  output logic              vecValid,
  output logic [IDX_W-1:0]  vecIndex
);

  logic [DATA_W-1:0] causeReg, maskReg;
  logic [DATA_W-1:0] causeNext, maskNext;
  logic [DATA_W-1:0] srcWide, keepBits, causeView;
  logic [SRC_HI:SRC_LO] pend;

  always_comb begin
    srcWide = '0;
    srcWide[SRC_HI:SRC_LO] = srcIn;
  end

  // a 1 in write data keeps the bit, a 0 clears it; sources override
  assign keepBits  = strobe.causeWr ? wrData : '1;
  assign causeNext = ((causeReg & keepBits) | srcWide) & SRC_FIELD;
  assign maskNext  = strobe.maskWr ? (wrData & SRC_FIELD) : maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeReg <= '0;
      maskReg  <= '0;
    end else begin
      causeReg <= causeNext;
      maskReg  <= maskNext;
    end
  end

  always_comb begin
    causeView = causeReg;
    causeView[SUM_ALL_POS] = |(causeReg & SRC_FIELD);
    causeView[SUM_A_POS]   = |(causeReg & GRP_A);
    causeView[SUM_B_POS]   = |(causeReg & GRP_B);
  end

  always_comb begin
    case (strobe.rdSel)
      RD_CAUSE: rdData = causeView;
      RD_MASK:  rdData = maskReg;
      default:  rdData = '0;
    endcase
  end

  assign pend   = causeReg[SRC_HI:SRC_LO] & maskReg[SRC_HI:SRC_LO];
  assign cpuIrq = |pend;

  irq_ctrl_prienc #(.LO(SRC_LO), .HI(SRC_HI), .IW(IDX_W)) u_prienc (
    .pend  (pend),
    .valid (vecValid),
    .idx   (vecIndex)
  );

  // ---------------------------------------------------------------
  logic [DATA_W-1:0] pendChk;
  assign pendChk = causeReg & maskReg;

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (causeReg == '0 && maskReg == '0));

  a_r2_source_latched: assert property (@(posedge clk) disable iff (!rstN)
    (srcWide != '0) |=> ((causeReg & $past(srcWide)) == $past(srcWide)));

  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.causeWr |=> ((causeReg & ~$past(srcWide) & ~$past(wrData)) == '0));

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN)
    ((causeReg & ~$past(causeReg) & ~$past(srcWide)) == '0));

  a_r7_mask_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.maskWr |=> $stable(maskReg));

  a_r8_irq_matches_vector: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == vecValid);

  a_r9_winner_pending: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> pendChk[vecIndex]);

  a_r9_winner_lowest: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> ((pendChk & ((DATA_W'(1) << vecIndex) - DATA_W'(1))) == '0));

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_HI:SRC_LO] srcIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 cpuIrq,
  output logic                 vecValid,
  output logic [IDX_W-1:0]     vecIndex
);

  strobe_t strobe;

  irq_ctrl_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  irq_ctrl_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .wrData   (regWrData),
    .strobe   (strobe),
    .rdData   (regRdData),
    .cpuIrq   (cpuIrq),
    .vecValid (vecValid),
    .vecIndex (vecIndex)
  );

endmodule

// File: tb/test_irq_cause_ctrl.sv
`timescale 1ns/1ps
module test_irq_cause_ctrl;

  logic        clk = 1'b0;
  logic        rstN;
  logic [29:1] srcIn;
  logic [1:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        cpuIrq, vecValid;
  logic [4:0]  vecIndex;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_cause_ctrl i_irq_cause_ctrl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .cpuIrq(cpuIrq), .vecValid(vecValid), .vecIndex(vecIndex)
  );

  typedef struct {
    logic [31:0] data;
    logic        irq;
    logic        valid;
    logic [4:0]  idx;
    string       tag;
  } exp_t;

  exp_t sbQ[$];

  // expected cause view built from the summary rules
  function automatic logic [31:0] view(logic [31:0] c);
    logic [31:0] r;
    r = c & 32'h3FFF_FFFE;
    if (|r) r[0] = 1'b1;
    if (|(r & 32'h3C1F_FFFE)) r[30] = 1'b1;
    if (|(r & 32'h03FF_FFFE)) r[31] = 1'b1;
    return r;
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compares after outputs settle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbQ.size() > 0) begin
        exp_t e;
        e = sbQ.pop_front();
        cmp(e.tag, "rdData", regRdData, e.data);
        cmp(e.tag, "cpuIrq", 32'(cpuIrq), 32'(e.irq));
        cmp(e.tag, "vecValid", 32'(vecValid), 32'(e.valid));
        cmp(e.tag, "vecIndex", 32'(vecIndex), 32'(e.idx));
      end
    end
  end

  task automatic expectAt(logic [1:0] a, logic [31:0] d, logic irq, logic v,
                          logic [4:0] ix, string tag);
    exp_t e;
    @(negedge clk);
    regAddr = a;
    e.data = d; e.irq = irq; e.valid = v; e.idx = ix; e.tag = tag;
    sbQ.push_back(e);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(logic [31:0] s);
    @(negedge clk);
    srcIn = s[29:1];
    @(negedge clk);
    srcIn = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bitList[6] = '{1, 20, 21, 25, 26, 29};
    logic [31:0] sumExp[6] = '{32'hC000_0003, 32'hC010_0001, 32'h8020_0001,
                               32'h8200_0001, 32'h4400_0001, 32'h6000_0001};
    rstN = 1'b0; srcIn = '0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    expectAt(2'd0, 32'h0, 1'b0, 1'b0, 5'd0, "R1");
    expectAt(2'd1, 32'h0, 1'b0, 1'b0, 5'd0, "R1");

    // R2: latched after the source drops; mask zero keeps the line low (R8)
    pulse(32'h1 << 5);
    expectAt(2'd0, view(32'h1 << 5), 1'b0, 1'b0, 5'd0, "R2");
    expectAt(2'd0, view(32'h1 << 5), 1'b0, 1'b0, 5'd0, "R8");

    // R7: enable source 5
    wr(2'd1, 32'h1 << 5);
    expectAt(2'd1, 32'h1 << 5, 1'b1, 1'b1, 5'd5, "R7");
    wr(2'd1, 32'hFFFF_FFFF);
    expectAt(2'd1, 32'h3FFF_FFFE, 1'b1, 1'b1, 5'd5, "R7");

    // R9: lowest enabled pending source wins
    pulse((32'h1 << 3) | (32'h1 << 27));
    expectAt(2'd0, view(32'h0800_0028), 1'b1, 1'b1, 5'd3, "R9");

    // R3: clear one bit only
    wr(2'd0, ~(32'h1 << 3));
    expectAt(2'd0, view(32'h0800_0020), 1'b1, 1'b1, 5'd5, "R3");
    // R3/R5: writing ones, including summary positions, changes nothing
    wr(2'd0, 32'hFFFF_FFFF);
    expectAt(2'd0, view(32'h0800_0020), 1'b1, 1'b1, 5'd5, "R3");
    wr(2'd0, 32'h3FFF_FFFE);
    expectAt(2'd0, view(32'h0800_0020), 1'b1, 1'b1, 5'd5, "R5");
    // clear everything: R9 reports nothing pending
    wr(2'd0, 32'h0);
    expectAt(2'd0, 32'h0, 1'b0, 1'b0, 5'd0, "R3");
    expectAt(2'd0, 32'h0, 1'b0, 1'b0, 5'd0, "R9");

    // R6: summary positions for group edge sources
    for (int k = 0; k < 6; k++) begin
      pulse(32'h1 << bitList[k]);
      expectAt(2'd0, sumExp[k], 1'b1, 1'b1, 5'(bitList[k]), "R6");
      wr(2'd0, 32'h0);
    end

    // R4: set wins over a simultaneous clear
    @(negedge clk);
    srcIn = '0; srcIn[9] = 1'b1;
    wr(2'd0, ~(32'h1 << 9));
    srcIn = '0;
    expectAt(2'd0, 32'hC000_0201, 1'b1, 1'b1, 5'd9, "R4");
    wr(2'd0, ~(32'h1 << 9));
    expectAt(2'd0, 32'h0, 1'b0, 1'b0, 5'd0, "R4");

    // R10: masking keeps the cause bit, unmasking raises the line again
    pulse(32'h1 << 12);
    wr(2'd1, 32'h0);
    expectAt(2'd0, 32'hC000_1001, 1'b0, 1'b0, 5'd0, "R10");
    wr(2'd1, 32'h1 << 12);
    expectAt(2'd0, 32'hC000_1001, 1'b1, 1'b1, 5'd12, "R10");

    // R11: unmapped addresses read zero and write nothing
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0);
    expectAt(2'd2, 32'h0, 1'b1, 1'b1, 5'd12, "R11");
    expectAt(2'd0, 32'hC000_1001, 1'b1, 1'b1, 5'd12, "R11");
    expectAt(2'd1, 32'h1 << 12, 1'b1, 1'b1, 5'd12, "R11");

    // R9: the two top sources, the lower of them wins
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    pulse((32'h1 << 28) | (32'h1 << 29));
    expectAt(2'd0, 32'h7000_0001, 1'b1, 1'b1, 5'd28, "R9");

    @(negedge clk);
    #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule